// File: doc/BRIEF.md
# Hybrid Value Prediction Selector

This block merges the guesses of two value predictors, one that keys on control-flow context and one that extrapolates by stride, into a single result for the rename stage. On each lookup, each predictor presents a candidate value and a flag saying whether it is confident enough to be used. The selector applies agreement rules and, one cycle later, presents a final value with a valid flag. When the two predictors are confident and disagree, the selector makes no prediction, because a wrong value costs far more than a missed one.

The same cycle, the selector sends a speculative last value back to the stride predictor so that the stride predictor can predict a back-to-back occurrence of the same instruction. A confident context guess always takes that slot, even when it conflicts with the stride guess. Otherwise the slot carries the chosen prediction. At retirement, the committed result is sent on one training bus that both predictors listen to. The predictors themselves lie outside this block.

Top module: `hybrid_value_select`

## Requirements
- R1: On a lookup where exactly one predictor is confident, `predValid` is 1 one cycle later and `predValue` equals that predictor's value.
- R2: On a lookup where both predictors are confident and their values differ, `predValid` is 0 one cycle later.
- R3: On a lookup where both predictors are confident and their values are equal, `predValid` is 1 one cycle later and `predValue` equals the shared value.
- R4: On a lookup where neither predictor is confident, `predValid` is 0 one cycle later.
- R5: On a lookup where the context predictor is confident, `specWrite` is 1 one cycle later and `specValue` equals the context value, whatever the stride predictor offers.
- R6: On a lookup where only the stride predictor is confident, `specWrite` is 1 one cycle later and `specValue` equals the stride value. On a lookup where the context predictor is not confident and no prediction is made, `specWrite` is 0.
- R7: A cycle with `retireValid` high gives `trainValid` high one cycle later, with `trainValue` equal to the retired value. Without a retirement, `trainValid` is 0.
- R8: A cycle with `lookupValid` low gives `predValid` and `specWrite` low one cycle later, whatever the confidence flags are.
- R9: While a valid flag is 0, its value bus reads 0. During reset and in the first cycle after reset, all valid flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A lookup is presented this cycle |
| ctxConf | input | 1 | Context predictor is confident |
| ctxValue | input | VAL_W | Context predictor value |
| strConf | input | 1 | Stride predictor is confident |
| strValue | input | VAL_W | Stride predictor value |
| retireValid | input | 1 | An instruction with a predicted result retires |
| retireValue | input | VAL_W | Committed result |
| predValid | output | 1 | Final prediction is usable |
| predValue | output | VAL_W | Final prediction |
| specWrite | output | 1 | Write the stride predictor's speculative last value |
| specValue | output | VAL_W | Speculative last value for the stride predictor |
| trainValid | output | 1 | Training broadcast to both predictors |
| trainValue | output | VAL_W | Committed value for training |

## Verification
Every result is due exactly one clock edge after its stimulus. This holds for the prediction, the speculative write-back and the training broadcast. The bench drives the inputs on the falling edge and computes the expected outputs from the rules at that moment. It compares them just after the next rising edge, so each check sees only the stimulus of the previous cycle. A following idle cycle confirms that the lookup-gating rule and the zero-when-invalid rule hold, and that no output stays set from the cycle before.

// File: rtl/hvs_pkg.sv
package hvs_pkg;
  typedef struct packed {
    logic makePred;
    logic pickCtx;
    logic specWr;
    logic specFromCtx;
    logic trainWr;
  } hvsCtrl_t;
endpackage

// File: rtl/hvs_ctrl.sv
module hvs_ctrl
  import hvs_pkg::*;
(
  input  logic     lookupValid,
  input  logic     ctxConf,
  input  logic     strConf,
  input  logic     valEq,
  input  logic     retireValid,
  output hvsCtrl_t ctrl
);
  logic onlyOne;
  logic bothAgree;

  always_comb begin
    onlyOne          = ctxConf ^ strConf;
    bothAgree        = ctxConf & strConf & valEq;
    ctrl.makePred    = lookupValid & (onlyOne | bothAgree);
    ctrl.pickCtx     = ctxConf;
    ctrl.specWr      = lookupValid & (ctxConf | onlyOne | bothAgree);
    ctrl.specFromCtx = ctxConf;
    ctrl.trainWr     = retireValid;
  end
endmodule

// File: rtl/hvs_datapath.sv
module hvs_datapath
  import hvs_pkg::*;
#(
  parameter int VAL_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  hvsCtrl_t         ctrl,
  input  logic [VAL_W-1:0] ctxValue,
  input  logic [VAL_W-1:0] strValue,
  input  logic [VAL_W-1:0] retireValue,
  output logic             valEq,
  output logic             predValid,
  output logic [VAL_W-1:0] predValue,
  output logic             specWrite,
  output logic [VAL_W-1:0] specValue,
  output logic             trainValid,
  output logic [VAL_W-1:0] trainValue
);
  logic [VAL_W-1:0] chosen;
  logic [VAL_W-1:0] specNext;

  always_comb begin
    valEq    = (ctxValue == strValue);
    chosen   = ctrl.pickCtx ? ctxValue : strValue;
    specNext = ctrl.specFromCtx ? ctxValue : strValue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      predValid  <= 1'b0;
      predValue  <= '0;
      specWrite  <= 1'b0;
      specValue  <= '0;
      trainValid <= 1'b0;
      trainValue <= '0;
    end else begin
      predValid  <= ctrl.makePred;
      predValue  <= ctrl.makePred ? chosen : '0;
      specWrite  <= ctrl.specWr;
      specValue  <= ctrl.specWr ? specNext : '0;
      trainValid <= ctrl.trainWr;
      trainValue <= ctrl.trainWr ? retireValue : '0;
    end
  end
endmodule

// File: rtl/hybrid_value_select.sv
module hybrid_value_select
  import hvs_pkg::*;
#(
  parameter int VAL_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic             ctxConf,
  input  logic [VAL_W-1:0] ctxValue,
  input  logic             strConf,
  input  logic [VAL_W-1:0] strValue,
  input  logic             retireValid,
  input  logic [VAL_W-1:0] retireValue,
  output logic             predValid,
  output logic [VAL_W-1:0] predValue,
  output logic             specWrite,
  output logic [VAL_W-1:0] specValue,
  output logic             trainValid,
  output logic [VAL_W-1:0] trainValue
);
  hvsCtrl_t ctrl;
  logic     valEq;

  hvs_ctrl u_ctrl (
    .lookupValid(lookupValid),
    .ctxConf    (ctxConf),
    .strConf    (strConf),
    .valEq      (valEq),
    .retireValid(retireValid),
    .ctrl       (ctrl)
  );

  hvs_datapath #(.VAL_W(VAL_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .ctxValue   (ctxValue),
    .strValue   (strValue),
    .retireValue(retireValue),
    .valEq      (valEq),
    .predValid  (predValid),
    .predValue  (predValue),
    .specWrite  (specWrite),
    .specValue  (specValue),
    .trainValid (trainValid),
    .trainValue (trainValue)
  );
endmodule

// File: rtl/hvs_checker.sv
module hvs_checker #(
  parameter int VAL_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             lookupValid,
  input logic             ctxConf,
  input logic [VAL_W-1:0] ctxValue,
  input logic             strConf,
  input logic [VAL_W-1:0] strValue,
  input logic             retireValid,
  input logic [VAL_W-1:0] retireValue,
  input logic             predValid,
  input logic [VAL_W-1:0] predValue,
  input logic             specWrite,
  input logic [VAL_W-1:0] specValue,
  input logic             trainValid,
  input logic [VAL_W-1:0] trainValue
);
  a_r1_single_confident: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid && ctxConf && !strConf |=> predValid && predValue == $past(ctxValue));

  a_r2_disagree_silent: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid && ctxConf && strConf && ctxValue != strValue |=> !predValid);

  a_r4_none_silent: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid && !ctxConf && !strConf |=> !predValid);

  a_r5_ctx_to_stride: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid && ctxConf |=> specWrite && specValue == $past(ctxValue));

  a_r7_train_bcast: assert property (@(posedge clk) disable iff (!rstN)
    retireValid |=> trainValid && trainValue == $past(retireValue));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !predValid && !specWrite);

  a_r9_zero_invalid: assert property (@(posedge clk) disable iff (!rstN)
    !predValid |-> predValue == '0);
endmodule

bind hybrid_value_select hvs_checker #(.VAL_W(VAL_W)) u_chk (.*);

// File: tb/hybrid_value_select_tb.sv
module hybrid_value_select_tb;
  localparam int VAL_W = 64;
  localparam time CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rstN;
  logic             lookupValid, ctxConf, strConf, retireValid;
  logic [VAL_W-1:0] ctxValue, strValue, retireValue;
  logic             predValid, specWrite, trainValid;
  logic [VAL_W-1:0] predValue, specValue, trainValue;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hybrid_value_select #(.VAL_W(VAL_W)) u_dut (.*);

  task automatic check(string req, string what, logic [VAL_W-1:0] act, logic [VAL_W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic expPredValid(logic lk, logic cc, logic sc, logic [VAL_W-1:0] cv, logic [VAL_W-1:0] sv);
    if (!lk) return 1'b0;
    if (cc && sc) return cv == sv;
    return cc || sc;
  endfunction

  function automatic logic [VAL_W-1:0] expPredValue(logic lk, logic cc, logic sc, logic [VAL_W-1:0] cv, logic [VAL_W-1:0] sv);
    if (!expPredValid(lk, cc, sc, cv, sv)) return '0;
    return cc ? cv : sv;
  endfunction

  function automatic logic expSpecWrite(logic lk, logic cc, logic sc, logic [VAL_W-1:0] cv, logic [VAL_W-1:0] sv);
    return lk && (cc || expPredValid(lk, cc, sc, cv, sv));
  endfunction

  function automatic logic [VAL_W-1:0] expSpecValue(logic lk, logic cc, logic sc, logic [VAL_W-1:0] cv, logic [VAL_W-1:0] sv);
    if (!expSpecWrite(lk, cc, sc, cv, sv)) return '0;
    return cc ? cv : sv;
  endfunction

  // one stimulus cycle: drive at negedge, check right after the next posedge
  task automatic step(string req, logic lk, logic cc, logic [VAL_W-1:0] cv, logic sc,
                      logic [VAL_W-1:0] sv, logic rv, logic [VAL_W-1:0] rval);
    logic             eP, eS;
    logic [VAL_W-1:0] ePv, eSv;
    @(negedge clk);
    lookupValid = lk; ctxConf = cc; ctxValue = cv; strConf = sc; strValue = sv;
    retireValid = rv; retireValue = rval;
    eP  = expPredValid(lk, cc, sc, cv, sv);
    ePv = expPredValue(lk, cc, sc, cv, sv);
    eS  = expSpecWrite(lk, cc, sc, cv, sv);
    eSv = expSpecValue(lk, cc, sc, cv, sv);
    @(posedge clk); #1;
    check(req, "predValid", {63'd0, predValid}, {63'd0, eP});
    check(req, "predValue", predValue, ePv);
    check(req, "specWrite", {63'd0, specWrite}, {63'd0, eS});
    check(req, "specValue", specValue, eSv);
    check("R7", "trainValid", {63'd0, trainValid}, {63'd0, rv});
    check("R7", "trainValue", trainValue, rv ? rval : '0);
  endtask

  function automatic logic [VAL_W-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    rstN = 1'b0; lookupValid = 0; ctxConf = 0; strConf = 0; retireValid = 0;
    ctxValue = '0; strValue = '0; retireValue = '0;
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1;
    check("R9", "predValid in reset", {63'd0, predValid}, '0);
    check("R9", "specWrite in reset", {63'd0, specWrite}, '0);
    check("R9", "trainValid in reset", {63'd0, trainValid}, '0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R9", "predValid after reset", {63'd0, predValid}, '0);

    // directed corners
    step("R1", 1, 1, 64'hAAAA_0000_1111_2222, 0, 64'h5, 0, '0);
    step("R1", 1, 0, 64'h7, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, '0);
    step("R6", 1, 0, 64'h7, 1, 64'h1234, 0, '0);
    step("R2", 1, 1, 64'h10, 1, 64'h11, 0, '0);
    step("R5", 1, 1, 64'h8000_0000_0000_0000, 1, 64'h1, 0, '0);
    step("R3", 1, 1, 64'hDEAD_BEEF, 1, 64'hDEAD_BEEF, 0, '0);
    step("R4", 1, 0, 64'h3, 0, 64'h3, 0, '0);
    step("R8", 0, 1, 64'h3, 1, 64'h3, 0, '0);
    step("R8", 0, 1, 64'h9, 0, 64'h4, 1, 64'hCAFE);
    step("R7", 0, 0, '0, 0, '0, 1, 64'hFFFF_0000_FFFF_0000);
    step("R9", 0, 0, '0, 0, '0, 0, '0);

    // constrained random: small value pool so matches are frequent
    for (int i = 0; i < 3000; i++) begin
      logic [VAL_W-1:0] a, b;
      a = ($urandom_range(0, 3) == 0) ? rnd64() : {62'd0, 2'($urandom_range(0, 3))};
      b = ($urandom_range(0, 1) == 0) ? a : rnd64();
      step("R1-R8 random", 1'($urandom_range(0, 3) != 0), 1'($urandom()), a,
           1'($urandom()), b, 1'($urandom()), rnd64());
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule